// File: doc/BRIEF.md
# PCIe Link Bring-Up Speed Sequencer

This block brings up a PCIe root-port link in two steps. It first limits the controller to Gen1 and enables the link training state machine. Once the link reports up and is no longer training, it lifts the limit to Gen2, starts a directed speed change and polls until that change finishes. It then confirms the link once more and returns the generation that was negotiated. All controller accesses go through a simple request/acknowledge register master port. Every read-modify-write changes only the bits it names.

Each of the three waits can fail: the first link-up, the speed change and the second link-up. Any failure sends the sequencer through one shared recovery step. Through a separate request/acknowledge port toward a PHY access engine, it pulses the receiver data-enable and receiver PLL-enable override bits on for a timed interval and then clears them. It then ends with an error flag and a 2-bit cause code. A single-cycle `start` launches a run. The `done` output stays high until the next `start`.

Top module: `lb_link_trainer`

## Requirements
- R1: On `start` the block clears `ltssm_en`, reads register 0x07C and writes it back with bits [3:0] = 1 and all other bits unchanged. `ltssm_en` rises only after that write completes, and it stays high until the next `start`.
- R2: The link counts as up only when a read of register 0x72C returns bit 4 = 1 and bit 29 = 0. If this is not seen within LINK_TIMEOUT cycles after `ltssm_en` rises, the run fails with `err_cause` = 1.
- R3: After the first good link-up, register 0x07C is rewritten with bits [3:0] = 2. Register 0x80C is then read and rewritten with bit 17 set. In both writes all other bits are kept.
- R4: Register 0x80C is polled until bit 17 reads 0. At most POLL_MAX polls are made, and two polls are at least POLL_GAP cycles apart. If the POLL_MAX-th poll reads 0, the run continues. If all POLL_MAX polls read 1, the run fails with `err_cause` = 2.
- R5: After the speed change completes, the link-up test of R2 is repeated with a fresh LINK_TIMEOUT window. A timeout fails the run with `err_cause` = 3.
- R6: On success the block reads register 0x080 and sets `link_gen` to bits [19:16]. It then raises `done` with `error` = 0 and `err_cause` = 0.
- R7: On any failure the block reads PHY register 0x1005 and writes it back with bits 5 and 3 set. It waits at least RECOV_WAIT cycles, reads the register again and writes it back with bits 5 and 3 cleared. All other bits are kept in both writes. It then raises `done` and `error`. On success no PHY access is made.
- R8: Each port has at most one transfer outstanding. A request holds its address, direction and write data stable until the acknowledge cycle. The register and PHY requests are never high together.
- R9: After reset all outputs are 0. A `start` pulse that arrives while a run is in progress has no effect.
- R10: A `start` after `done` clears `done`, `error`, `err_cause`, `link_gen` and `ltssm_en` on the next cycle, and the full sequence runs again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a bring-up run (ignored while busy) |
| reg_req | output | 1 | Register access request |
| reg_we | output | 1 | 1 = write, 0 = read |
| reg_addr | output | AW | Register byte offset |
| reg_wdata | output | DW | Register write data |
| reg_ack | input | 1 | Register access complete (read data valid) |
| reg_rdata | input | DW | Register read data |
| ltssm_en | output | 1 | Enables link training in the controller |
| phy_req | output | 1 | PHY access request |
| phy_we | output | 1 | 1 = write, 0 = read |
| phy_addr | output | PAW | PHY register address |
| phy_wdata | output | PDW | PHY write data |
| phy_ack | input | 1 | PHY access complete |
| phy_rdata | input | PDW | PHY read data |
| done | output | 1 | Run finished (held until next start) |
| error | output | 1 | Run ended in failure |
| err_cause | output | 2 | 0 none, 1 first link timeout, 2 speed-change timeout, 3 second link timeout |
| link_gen | output | 4 | Negotiated generation |

## Verification
The hardest cases to reach are the two edges of the poll budget: the speed-change bit clearing on exactly the last allowed poll, and never clearing at all. Close to these is a link that comes up, survives the speed change and then drops. The bench's controller model has settings for each run. They give the number of polls that return the busy bit before it clears, the delay to link-up, how long in-training is held, and whether the link drops after the speed change. Setting these reaches each situation directly, with no dependence on timing accidents.

// File: rtl/lb_pkg.sv
package lb_pkg;

    typedef enum logic [4:0] {
        ST_IDLE,
        ST_CAP_RD,
        ST_CAP_WR,
        ST_LINK1,
        ST_UP_RD,
        ST_UP_WR,
        ST_SPD_RD,
        ST_SPD_WR,
        ST_POLL,
        ST_GAP,
        ST_LINK2,
        ST_GEN_RD,
        ST_REC_RD1,
        ST_REC_WR1,
        ST_REC_WAIT,
        ST_REC_RD2,
        ST_REC_WR2,
        ST_FINISH
    } lb_state_e;

    typedef enum logic [1:0] {
        CAUSE_NONE  = 2'd0,
        CAUSE_LINK1 = 2'd1,
        CAUSE_SPEED = 2'd2,
        CAUSE_LINK2 = 2'd3
    } lb_cause_e;

    // controller register offsets
    localparam int ADDR_SPEED_CAP = 'h07C;
    localparam int ADDR_LINK_STAT = 'h080;
    localparam int ADDR_PHY_DEBUG = 'h72C;
    localparam int ADDR_SPD_CTRL  = 'h80C;
    // PHY receiver override register
    localparam int ADDR_RX_OVR    = 'h1005;

    // bit positions
    localparam int BIT_LINK_UP  = 4;
    localparam int BIT_TRAINING = 29;
    localparam int BIT_SPD_CHG  = 17;
    localparam int LSB_GEN      = 16;
    localparam int BIT_RX_DATA  = 5;
    localparam int BIT_RX_PLL   = 3;

    localparam logic [3:0] CAP_GEN1 = 4'd1;
    localparam logic [3:0] CAP_GEN2 = 4'd2;

endpackage

// File: rtl/lb_timer.sv
module lb_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] val,
    output logic         zero
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign zero = (cnt_q == '0);

endmodule

// File: rtl/lb_field_merge.sv
module lb_field_merge #(
    parameter int W = 32
) (
    input  logic [W-1:0] base,
    input  logic [W-1:0] clr_mask,
    input  logic [W-1:0] set_mask,
    output logic [W-1:0] merged
);
    always_comb begin
        merged = (base & ~clr_mask) | set_mask;
    end
endmodule

// File: rtl/lb_link_trainer.sv
module lb_link_trainer
    import lb_pkg::*;
#(
    parameter int LINK_TIMEOUT = 400,
    parameter int POLL_MAX     = 200,
    parameter int POLL_GAP     = 20,
    parameter int RECOV_WAIT   = 300,
    parameter int AW           = 12,
    parameter int DW           = 32,
    parameter int PAW          = 16,
    parameter int PDW          = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    output logic           reg_req,
    output logic           reg_we,
    output logic [AW-1:0]  reg_addr,
    output logic [DW-1:0]  reg_wdata,
    input  logic           reg_ack,
    input  logic [DW-1:0]  reg_rdata,
    output logic           ltssm_en,
    output logic           phy_req,
    output logic           phy_we,
    output logic [PAW-1:0] phy_addr,
    output logic [PDW-1:0] phy_wdata,
    input  logic           phy_ack,
    input  logic [PDW-1:0] phy_rdata,
    output logic           done,
    output logic           error,
    output logic [1:0]     err_cause,
    output logic [3:0]     link_gen
);
    localparam int TMAX_A = (LINK_TIMEOUT > POLL_GAP) ? LINK_TIMEOUT : POLL_GAP;
    localparam int TMAX   = (TMAX_A > RECOV_WAIT) ? TMAX_A : RECOV_WAIT;
    localparam int TW     = $clog2(TMAX + 1);
    localparam int PCW    = $clog2(POLL_MAX + 1);

    typedef struct packed {
        lb_state_e        st;
        logic [DW-1:0]    wdata;
        logic [PDW-1:0]   pwdata;
        logic             ltssm;
        logic             done;
        logic             err;
        lb_cause_e        cause;
        logic [3:0]       gen;
        logic [PCW-1:0]   polls;
    } ctl_t;

    ctl_t c_d, c_q;

    logic           lnk_load, lnk_zero;
    logic           wt_load, wt_zero;
    logic [TW-1:0]  wt_val;
    logic [DW-1:0]  r_clr, r_set, r_merged;
    logic [PDW-1:0] p_clr, p_set, p_merged;
    logic [PCW-1:0] poll_nxt;
    logic           link_good;

    assign poll_nxt  = c_q.polls + 1'b1;
    assign link_good = reg_rdata[BIT_LINK_UP] && !reg_rdata[BIT_TRAINING];

    // link-up window timer
    lb_timer #(.W(TW)) u_lnk_tmr (
        .clk  (clk),
        .rst_n(rst_n),
        .load (lnk_load),
        .val  (TW'(LINK_TIMEOUT)),
        .zero (lnk_zero)
    );

    // poll spacing / recovery hold timer
    lb_timer #(.W(TW)) u_wait_tmr (
        .clk  (clk),
        .rst_n(rst_n),
        .load (wt_load),
        .val  (wt_val),
        .zero (wt_zero)
    );

    lb_field_merge #(.W(DW)) u_reg_merge (
        .base    (reg_rdata),
        .clr_mask(r_clr),
        .set_mask(r_set),
        .merged  (r_merged)
    );

    lb_field_merge #(.W(PDW)) u_phy_merge (
        .base    (phy_rdata),
        .clr_mask(p_clr),
        .set_mask(p_set),
        .merged  (p_merged)
    );

    // field masks for each read-modify-write, chosen by state
    always_comb begin
        r_clr = '0;
        r_set = '0;
        p_clr = '0;
        p_set = '0;
        case (c_q.st)
            ST_CAP_RD: begin
                r_clr = DW'(4'hF);
                r_set = DW'(CAP_GEN1);
            end
            ST_UP_RD: begin
                r_clr = DW'(4'hF);
                r_set = DW'(CAP_GEN2);
            end
            ST_SPD_RD: begin
                r_set = DW'(1) << BIT_SPD_CHG;
            end
            ST_REC_RD1: begin
                p_set = (PDW'(1) << BIT_RX_DATA) | (PDW'(1) << BIT_RX_PLL);
            end
            ST_REC_RD2: begin
                p_clr = (PDW'(1) << BIT_RX_DATA) | (PDW'(1) << BIT_RX_PLL);
            end
            default: ;
        endcase
    end

    // next-state computation
    always_comb begin
        c_d      = c_q;
        lnk_load = 1'b0;
        wt_load  = 1'b0;
        wt_val   = TW'(POLL_GAP);
        case (c_q.st)
            ST_IDLE, ST_FINISH: begin
                if (start) begin
                    c_d.st    = ST_CAP_RD;
                    c_d.ltssm = 1'b0;
                    c_d.done  = 1'b0;
                    c_d.err   = 1'b0;
                    c_d.cause = CAUSE_NONE;
                    c_d.gen   = '0;
                    c_d.polls = '0;
                end
            end
            ST_CAP_RD: if (reg_ack) begin
                c_d.wdata = r_merged;
                c_d.st    = ST_CAP_WR;
            end
            ST_CAP_WR: if (reg_ack) begin
                c_d.ltssm = 1'b1;
                lnk_load  = 1'b1;
                c_d.st    = ST_LINK1;
            end
            ST_LINK1: if (reg_ack) begin
                if (link_good) begin
                    c_d.st = ST_UP_RD;
                end else if (lnk_zero) begin
                    c_d.cause = CAUSE_LINK1;
                    c_d.st    = ST_REC_RD1;
                end
            end
            ST_UP_RD: if (reg_ack) begin
                c_d.wdata = r_merged;
                c_d.st    = ST_UP_WR;
            end
            ST_UP_WR: if (reg_ack) begin
                c_d.st = ST_SPD_RD;
            end
            ST_SPD_RD: if (reg_ack) begin
                c_d.wdata = r_merged;
                c_d.st    = ST_SPD_WR;
            end
            ST_SPD_WR: if (reg_ack) begin
                c_d.polls = '0;
                c_d.st    = ST_POLL;
            end
            ST_POLL: if (reg_ack) begin
                if (!reg_rdata[BIT_SPD_CHG]) begin
                    lnk_load = 1'b1;
                    c_d.st   = ST_LINK2;
                end else begin
                    c_d.polls = poll_nxt;
                    if (poll_nxt >= PCW'(POLL_MAX)) begin
                        c_d.cause = CAUSE_SPEED;
                        c_d.st    = ST_REC_RD1;
                    end else begin
                        wt_load = 1'b1;
                        wt_val  = TW'(POLL_GAP);
                        c_d.st  = ST_GAP;
                    end
                end
            end
            ST_GAP: if (wt_zero) begin
                c_d.st = ST_POLL;
            end
            ST_LINK2: if (reg_ack) begin
                if (link_good) begin
                    c_d.st = ST_GEN_RD;
                end else if (lnk_zero) begin
                    c_d.cause = CAUSE_LINK2;
                    c_d.st    = ST_REC_RD1;
                end
            end
            ST_GEN_RD: if (reg_ack) begin
                c_d.gen  = reg_rdata[LSB_GEN +: 4];
                c_d.done = 1'b1;
                c_d.st   = ST_FINISH;
            end
            ST_REC_RD1: if (phy_ack) begin
                c_d.pwdata = p_merged;
                c_d.st     = ST_REC_WR1;
            end
            ST_REC_WR1: if (phy_ack) begin
                wt_load = 1'b1;
                wt_val  = TW'(RECOV_WAIT);
                c_d.st  = ST_REC_WAIT;
            end
            ST_REC_WAIT: if (wt_zero) begin
                c_d.st = ST_REC_RD2;
            end
            ST_REC_RD2: if (phy_ack) begin
                c_d.pwdata = p_merged;
                c_d.st     = ST_REC_WR2;
            end
            ST_REC_WR2: if (phy_ack) begin
                c_d.done = 1'b1;
                c_d.err  = 1'b1;
                c_d.st   = ST_FINISH;
            end
            default: c_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q <= '{st: ST_IDLE, cause: CAUSE_NONE, default: '0};
        end else begin
            c_q <= c_d;
        end
    end

    // bus drive, decoded from the registered state
    always_comb begin
        reg_req  = 1'b0;
        reg_we   = 1'b0;
        reg_addr = '0;
        phy_req  = 1'b0;
        phy_we   = 1'b0;
        phy_addr = '0;
        case (c_q.st)
            ST_CAP_RD, ST_UP_RD: begin
                reg_req  = 1'b1;
                reg_addr = AW'(ADDR_SPEED_CAP);
            end
            ST_CAP_WR, ST_UP_WR: begin
                reg_req  = 1'b1;
                reg_we   = 1'b1;
                reg_addr = AW'(ADDR_SPEED_CAP);
            end
            ST_LINK1, ST_LINK2: begin
                reg_req  = 1'b1;
                reg_addr = AW'(ADDR_PHY_DEBUG);
            end
            ST_SPD_RD, ST_POLL: begin
                reg_req  = 1'b1;
                reg_addr = AW'(ADDR_SPD_CTRL);
            end
            ST_SPD_WR: begin
                reg_req  = 1'b1;
                reg_we   = 1'b1;
                reg_addr = AW'(ADDR_SPD_CTRL);
            end
            ST_GEN_RD: begin
                reg_req  = 1'b1;
                reg_addr = AW'(ADDR_LINK_STAT);
            end
            ST_REC_RD1, ST_REC_RD2: begin
                phy_req  = 1'b1;
                phy_addr = PAW'(ADDR_RX_OVR);
            end
            ST_REC_WR1, ST_REC_WR2: begin
                phy_req  = 1'b1;
                phy_we   = 1'b1;
                phy_addr = PAW'(ADDR_RX_OVR);
            end
            default: ;
        endcase
    end

    assign reg_wdata = c_q.wdata;
    assign phy_wdata = c_q.pwdata;
    assign ltssm_en  = c_q.ltssm;
    assign done      = c_q.done;
    assign error     = c_q.err;
    assign err_cause = c_q.cause;
    assign link_gen  = c_q.gen;

    // ---------------- assertions ----------------
    AST_REG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_req && !reg_ack) |=> (reg_req && $stable(reg_addr) && $stable(reg_we) && $stable(reg_wdata))); // R8

    AST_PHY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (phy_req && !phy_ack) |=> (phy_req && $stable(phy_addr) && $stable(phy_we) && $stable(phy_wdata))); // R8

    AST_BUS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_req && phy_req)); // R8

    AST_ERR_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        error |-> done); // R7

    AST_LTSSM_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (ltssm_en && !done) |=> ltssm_en); // R1

    AST_CLEAN_SUCCESS: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !error) |-> (err_cause == 2'd0 && !phy_req)); // R6

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!reg_req && !phy_req)); // R9

endmodule

// File: tb/sim_lb_link_trainer.sv
module sim_lb_link_trainer;
    localparam int LT = 400;
    localparam int PM = 200;
    localparam int PG = 20;
    localparam int RW = 300;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        reg_req, reg_we;
    logic [11:0] reg_addr;
    logic [31:0] reg_wdata;
    logic        reg_ack = 1'b0;
    logic [31:0] reg_rdata = '0;
    logic        ltssm_en;
    logic        phy_req, phy_we;
    logic [15:0] phy_addr, phy_wdata;
    logic        phy_ack = 1'b0;
    logic [15:0] phy_rdata = '0;
    logic        done, error;
    logic [1:0]  err_cause;
    logic [3:0]  link_gen;

    always #5 clk = ~clk;

    lb_link_trainer #(
        .LINK_TIMEOUT(LT), .POLL_MAX(PM), .POLL_GAP(PG), .RECOV_WAIT(RW)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .start(start),
        .reg_req(reg_req), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_ack(reg_ack), .reg_rdata(reg_rdata), .ltssm_en(ltssm_en),
        .phy_req(phy_req), .phy_we(phy_we), .phy_addr(phy_addr), .phy_wdata(phy_wdata),
        .phy_ack(phy_ack), .phy_rdata(phy_rdata),
        .done(done), .error(error), .err_cause(err_cause), .link_gen(link_gen)
    );

    // ---------------- behavioural controller / PHY model ----------------
    int tests = 0;
    int fails = 0;
    int cyc = 0;
    bit wd_hit = 0;
    int viol = 0;

    logic [31:0] r_cap, r_spd;
    logic [15:0] r_ovr;
    int link_delay, train_end, clear_after, gen_val, polls_seen, lt_cnt, lt_rise;
    bit link2_fail, spd_started, prev_lt;
    logic [31:0] cap_log[$];
    int          cap_times[$];
    logic [31:0] spd_log[$];
    logic [15:0] phy_log[$];
    int          phy_times[$];
    int          poll_times[$];

    always @(posedge clk) begin
        cyc = cyc + 1;
        if (!rst_n) begin
            reg_ack <= 1'b0;
            phy_ack <= 1'b0;
            lt_cnt  = 0;
            prev_lt = 0;
        end else begin
            if (ltssm_en && !prev_lt) begin
                lt_rise = cyc;
                if (r_cap[3:0] != 4'd1) viol++;
            end
            prev_lt = ltssm_en;
            if (ltssm_en) lt_cnt++; else lt_cnt = 0;

            if (reg_req && !reg_ack) begin
                logic [31:0] v;
                bit up;
                reg_ack <= 1'b1;
                v = '0;
                if (reg_we) begin
                    if (reg_addr == 12'h07C) begin
                        r_cap = reg_wdata;
                        cap_log.push_back(reg_wdata);
                        cap_times.push_back(cyc);
                    end else if (reg_addr == 12'h80C) begin
                        r_spd = reg_wdata;
                        spd_log.push_back(reg_wdata);
                        if (reg_wdata[17]) spd_started = 1;
                    end else viol++;
                end else begin
                    if (reg_addr == 12'h07C) v = r_cap;
                    else if (reg_addr == 12'h72C) begin
                        up = ltssm_en && (lt_cnt >= link_delay) && !(spd_started && link2_fail);
                        v[4]  = up;
                        v[29] = (lt_cnt < train_end);
                    end else if (reg_addr == 12'h80C) begin
                        if (r_spd[17]) begin
                            polls_seen++;
                            poll_times.push_back(cyc);
                            if (clear_after >= 0 && polls_seen > clear_after) r_spd[17] = 1'b0;
                        end
                        v = r_spd;
                    end else if (reg_addr == 12'h080) v = {12'h0, gen_val[3:0], 16'h0};
                    else viol++;
                    reg_rdata <= v;
                end
            end else begin
                reg_ack <= 1'b0;
            end

            if (phy_req && !phy_ack) begin
                phy_ack <= 1'b1;
                if (phy_addr != 16'h1005) viol++;
                if (phy_we) begin
                    r_ovr = phy_wdata;
                    phy_log.push_back(phy_wdata);
                    phy_times.push_back(cyc);
                end else begin
                    phy_rdata <= r_ovr;
                end
            end else begin
                phy_ack <= 1'b0;
            end
        end
    end

    // per-clock protocol monitor (R8)
    always @(negedge clk) begin
        if (rst_n && reg_req && phy_req) viol++;
        if (rst_n && error && !done) viol++;
    end

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
    endtask

    always @(negedge clk) begin
        if (cyc > 190000 && !wd_hit) begin
            wd_hit = 1;
            tests++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=<190000 cycles", cyc);
            summary();
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    localparam logic [31:0] CAP_INIT = 32'hABCD_123B;
    localparam logic [31:0] SPD_INIT = 32'h0001_0C42;
    localparam logic [15:0] OVR_INIT = 16'h1234;

    task automatic run(input int ld, input int te, input bit l2f, input int ca, input int gv,
                       input bit mid, input bit exp_err, input int exp_cause, input int exp_gen);
        int n;
        link_delay = ld; train_end = te; link2_fail = l2f; clear_after = ca; gen_val = gv;
        polls_seen = 0; spd_started = 0;
        r_cap = CAP_INIT; r_spd = SPD_INIT; r_ovr = OVR_INIT;
        cap_log.delete(); cap_times.delete(); spd_log.delete();
        phy_log.delete(); phy_times.delete(); poll_times.delete();
        viol = 0;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        chk(!done && !error && !ltssm_en && err_cause == 0 && link_gen == 0,
            "R10 start clears status", {done, error, ltssm_en}, 0);
        n = 0;
        while (!done && n < 30000) begin
            @(negedge clk);
            n++;
            start = (mid && n == 30);
        end
        start = 1'b0;
        chk(done, exp_err ? "R7 done after failure" : "R6 done after success", done, 1);
        chk(error == exp_err, exp_err ? "R7 error flag" : "R6 error flag", error, exp_err);
        case (exp_cause)
            1: chk(err_cause == 2'd1, "R2 cause first link", err_cause, 1);
            2: chk(err_cause == 2'd2, "R4 cause speed", err_cause, 2);
            3: chk(err_cause == 2'd3, "R5 cause second link", err_cause, 3);
            default: chk(err_cause == 2'd0, "R6 cause none", err_cause, 0);
        endcase
        chk(cap_log.size() > 0 && cap_log[0] == ((CAP_INIT & ~32'hF) | 32'h1),
            "R1 gen1 cap write", cap_log.size() > 0 ? cap_log[0] : 0, (CAP_INIT & ~32'hF) | 32'h1);
        if (!exp_err) begin
            chk(link_gen == exp_gen[3:0], "R6 link_gen", link_gen, exp_gen);
            chk(r_cap == ((CAP_INIT & ~32'hF) | 32'h2), "R3 gen2 cap write", r_cap,
                (CAP_INIT & ~32'hF) | 32'h2);
            chk(spd_log.size() == 1 && spd_log[0] == (SPD_INIT | 32'h0002_0000),
                "R3 speed change write", spd_log.size() > 0 ? spd_log[0] : 0, SPD_INIT | 32'h0002_0000);
            chk(phy_log.size() == 0, "R7 no PHY access on success", phy_log.size(), 0);
        end else begin
            chk(phy_log.size() == 2, "R7 two PHY writes", phy_log.size(), 2);
            if (phy_log.size() == 2) begin
                chk(phy_log[0] == (OVR_INIT | 16'h0028), "R7 override set", phy_log[0], OVR_INIT | 16'h0028);
                chk(phy_log[1] == (OVR_INIT & ~16'h0028), "R7 override clear", phy_log[1], OVR_INIT & ~16'h0028);
                chk(phy_times[1] - phy_times[0] >= RW, "R7 override hold time",
                    phy_times[1] - phy_times[0], RW);
            end
        end
        if (mid) chk(cap_log.size() == 2, "R9 start ignored while busy", cap_log.size(), 2);
        chk(viol == 0, "R8 bus protocol and ordering", viol, 0);
    endtask

    initial begin
        int mingap;
        repeat (5) @(negedge clk);
        chk(!done && !error && !ltssm_en && !reg_req && !phy_req && err_cause == 0 && link_gen == 0,
            "R9 reset state", {done, error, ltssm_en, reg_req, phy_req}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // success at Gen2, with a stray start mid-run
        run(10, 0, 0, 3, 2, 1, 0, 0, 2);
        chk(polls_seen == 4, "R4 poll count before clear", polls_seen, 4);

        // partner limited to Gen1
        run(25, 0, 0, 0, 1, 0, 0, 0, 1);

        // link reports up while still training
        run(5, 150, 0, 1, 2, 0, 0, 0, 2);
        chk(cap_times.size() == 2 && (cap_times[1] - lt_rise) >= 150, "R2 training blocks link-up",
            cap_times.size() == 2 ? cap_times[1] - lt_rise : -1, 150);

        // first link-up never arrives
        run(100000000, 0, 0, 0, 2, 0, 1, 1, 0);
        chk(cap_log.size() == 1, "R2 no gen2 write after timeout", cap_log.size(), 1);
        chk(lt_cnt >= LT, "R2 timeout window length", lt_cnt, LT);

        // speed change never completes
        run(10, 0, 0, PM, 2, 0, 1, 2, 0);
        chk(polls_seen == PM, "R4 poll budget exhausted", polls_seen, PM);
        mingap = 1000000;
        for (int i = 1; i < poll_times.size(); i++)
            if (poll_times[i] - poll_times[i-1] < mingap) mingap = poll_times[i] - poll_times[i-1];
        chk(mingap >= PG, "R4 poll spacing", mingap, PG);

        // speed change completes on the last allowed poll
        run(10, 0, 0, PM - 1, 2, 0, 0, 0, 2);
        chk(polls_seen == PM, "R4 last poll accepted", polls_seen, PM);

        // link drops after speed change
        run(10, 0, 1, 2, 2, 0, 1, 3, 0);

        // restart after a failure
        run(10, 0, 0, 1, 2, 0, 0, 0, 2);

        summary();
        $finish;
    end
endmodule